// File: doc/BRIEF.md
# Serial Audio Word Transmitter

This block turns a pair of parallel stereo samples into a serial bit stream for a downstream audio receiver. The bit clock, the frame (left/right) clock and an optional word clock all come from outside. The block runs on a faster system clock and oversamples them, so its output changes only on the chosen launch edge of the bit clock. Each channel word is 24 bits of two's-complement data, sent MSB first. The receiver may keep as many leading bits as it needs.

Four framings set where a word sits inside its channel half:
- left-aligned with no delay;
- left-aligned with a one-bit delay;
- right-aligned with the MSB a fixed number of bit clocks after the frame-clock transition;
- word-clock triggered.

A polarity input picks which bit-clock edge launches data. A mute input zeroes whole words. One holding register per channel is written through a load strobe. The pair is copied into the frame buffer when a left half begins, so a pair loaded mid-frame first appears in the following frame.

Top module: `ser_audio_tx`

## Requirements
- R1: Each channel word goes out MSB first as 24 bits. A word that starts while the synchronized frame clock is 0 carries the left sample, and one that starts while it is 1 carries the right sample.
- R2: `sdata_o` changes only on the system-clock edge at which a launch edge of the synchronized bit clock is seen. With `edge_pol_i` = 0 the launch edge is falling; with `edge_pol_i` = 1 it is rising. Each bit-clock, frame-clock and word-clock input passes through SYNC_STAGES flops before use.
- R3: In `frame_mode_i` = 2'b00 a word starts at the launch edge where a frame-clock change is seen, and its MSB goes out on that same launch edge.
- R4: In `frame_mode_i` = 2'b01 a word starts as in R3, but the MSB goes out one launch edge later.
- R5: In `frame_mode_i` = 2'b10 a word starts as in R3, but the MSB goes out RJ_OFFSET (default 16) launch edges after the frame-clock change.
- R6: In `frame_mode_i` = 2'b11 a word starts at the launch edge where the word clock is first seen high after being seen low. Its MSB goes out on that edge, and frame-clock changes start no word.
- R7: Every bit slot outside the 24 data slots of a word is 0. This includes all slots before the first word after reset.
- R8: `mute_i` is sampled only at a word start. A word that starts with mute high is all zeros, and a mute change in the middle of a word has no effect on that word.
- R9: `load_i` = 1 writes `left_i` and `right_i` into the holding registers. The pair is copied into the frame buffer at each frame-clock change to 0 seen on a launch edge, so a load made mid-frame shows up only in the next frame.
- R10: While `rst_n` is low, `sdata_o` is 0.
- R11: While the bit clock is gated, the output and the slot position hold, and transmission resumes where it paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | External serial bit clock, may be gated |
| frame_clk_i | input | 1 | External frame clock, 0 = left half, 1 = right half |
| word_clk_i | input | 1 | External word-start clock, used in mode 2'b11 |
| edge_pol_i | input | 1 | 0: launch on falling bit-clock edge, 1: on rising |
| frame_mode_i | input | 2 | Framing select (00, 01, 10, 11) |
| mute_i | input | 1 | 1 forces the next words to zero |
| load_i | input | 1 | Write strobe for the holding registers |
| left_i | input | WORD_W | Left sample, two's complement |
| right_i | input | WORD_W | Right sample, two's complement |
| sdata_o | output | 1 | Serial data out |

## Verification
The hardest case to reach from the ports is a mute or load that lands inside a word whose start has already been decided. The stimulus must place the change a set number of bit slots into the active half, then watch both the current word and the next one. The bench drives the bit, frame and word clocks itself, one slot at a time, and can inject mute changes, loads and a bit-clock gap at a chosen slot of a chosen half. A behavioural model replays the same synchronized clocks through queues and predicts each output bit.

// File: rtl/ser_audio_tx_pkg.sv
`timescale 1ns/1ps
package ser_audio_tx_pkg;

   typedef enum logic [1:0] {
      FRM_LEFT_ALIGN = 2'b00,
      FRM_LEFT_DELAY = 2'b01,
      FRM_RIGHT_FIX  = 2'b10,
      FRM_WORD_CLK   = 2'b11
   } frame_mode_e;

endpackage

// File: rtl/sat_clk_sense.sv
`timescale 1ns/1ps
module sat_clk_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_clk_i,
   input  logic frame_clk_i,
   input  logic word_clk_i,
   input  logic edge_pol_i,
   output logic launch_o,
   output logic frame_lvl_o,
   output logic frame_flip_o,
   output logic frame_fall_o,
   output logic word_rise_o
);

   logic [2:0] raw;
   logic [2:0] syn;
   logic       bit_prev;
   logic       frame_prev;
   logic       word_prev;

   assign raw = {word_clk_i, frame_clk_i, bit_clk_i};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign syn = raw;
      end else begin : g_sync
         logic [2:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign syn = stg[SYNC_STAGES-1];
      end
   endgenerate

   assign launch_o     = edge_pol_i ? (!bit_prev && syn[0]) : (bit_prev && !syn[0]);
   assign frame_lvl_o  = syn[1];
   assign frame_flip_o = launch_o && (syn[1] != frame_prev);
   assign frame_fall_o = frame_flip_o && !syn[1];
   assign word_rise_o  = launch_o && syn[2] && !word_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_prev   <= 1'b0;
         frame_prev <= 1'b0;
         word_prev  <= 1'b0;
      end else begin
         bit_prev <= syn[0];
         if (launch_o) begin
            frame_prev <= syn[1];
            word_prev  <= syn[2];
         end
      end
   end

endmodule

// File: rtl/sat_sample_bank.sv
`timescale 1ns/1ps
module sat_sample_bank #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] left_i,
   input  logic [WORD_W-1:0] right_i,
   input  logic              capture_i,
   input  logic              chan_i,
   output logic [WORD_W-1:0] word_o
);

   logic [WORD_W-1:0] left_q, right_q;
   logic [WORD_W-1:0] fr_left_q, fr_right_q;
   logic [WORD_W-1:0] fr_left_n, fr_right_n;

   assign fr_left_n  = capture_i ? left_q  : fr_left_q;
   assign fr_right_n = capture_i ? right_q : fr_right_q;
   assign word_o     = chan_i ? fr_right_n : fr_left_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q     <= '0;
         right_q    <= '0;
         fr_left_q  <= '0;
         fr_right_q <= '0;
      end else begin
         fr_left_q  <= fr_left_n;
         fr_right_q <= fr_right_n;
         if (load_i) begin
            left_q  <= left_i;
            right_q <= right_i;
         end
      end
   end

   assert_capture_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> (fr_left_q == $past(left_q)) && (fr_right_q == $past(right_q)));

   assert_hold_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> $stable(fr_left_q) && $stable(fr_right_q));

endmodule

// File: rtl/sat_slot_engine.sv
`timescale 1ns/1ps
module sat_slot_engine
   import ser_audio_tx_pkg::*;
#(
   parameter int WORD_W    = 24,
   parameter int RJ_OFFSET = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              start_i,
   input  frame_mode_e       mode_i,
   input  logic              mute_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              dout_o
);

   localparam int CNT_W = $clog2(RJ_OFFSET + WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0]  cnt_q, cnt_n, off;
   logic [CNT_W:0]    rel;
   logic [WORD_W-1:0] word_q, word_n, shifted;
   logic              mute_q, mute_n, dout_q, dout_n, in_word;

   always_comb begin
      unique case (mode_i)
         FRM_LEFT_DELAY: off = CNT_W'(1);
         FRM_RIGHT_FIX:  off = CNT_W'(RJ_OFFSET);
         default:        off = '0;
      endcase
   end

   always_comb begin
      cnt_n   = cnt_q;
      word_n  = word_q;
      mute_n  = mute_q;
      dout_n  = dout_q;
      rel     = '0;
      in_word = 1'b0;
      shifted = '0;
      if (launch_i) begin
         if (start_i) begin
            cnt_n  = '0;
            word_n = word_i;
            mute_n = mute_i;
         end else if (cnt_q != CNT_MAX) begin
            cnt_n = cnt_q + CNT_W'(1);
         end
         rel     = {1'b0, cnt_n} - {1'b0, off};
         in_word = (cnt_n >= off) && (rel < (CNT_W+1)'(WORD_W));
         shifted = word_n << rel[CNT_W-1:0];
         dout_n  = in_word && !mute_n && shifted[WORD_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_MAX;
         word_q <= '0;
         mute_q <= 1'b0;
         dout_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_n;
         word_q <= word_n;
         mute_q <= mute_n;
         dout_q <= dout_n;
      end
   end

   assign dout_o = dout_q;

   assert_launch_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !launch_i |=> $stable(dout_q));

   assert_gap_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !launch_i |=> $stable(cnt_q) && $stable(word_q));

   assert_muted_word_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_i && start_i && mute_i) |=> !dout_q);

   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !(launch_i && start_i)) |=> (cnt_q == CNT_MAX) && !dout_q);

endmodule

// File: rtl/ser_audio_tx.sv
`timescale 1ns/1ps
module ser_audio_tx
   import ser_audio_tx_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int RJ_OFFSET   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk_i,
   input  logic              frame_clk_i,
   input  logic              word_clk_i,
   input  logic              edge_pol_i,
   input  logic [1:0]        frame_mode_i,
   input  logic              mute_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] left_i,
   input  logic [WORD_W-1:0] right_i,
   output logic              sdata_o
);

   generate
      if (WORD_W < 4 || WORD_W > 32) begin : g_bad_width
         $error("ser_audio_tx: WORD_W must lie in 4..32");
      end
      if (RJ_OFFSET < 2) begin : g_bad_offset
         $error("ser_audio_tx: RJ_OFFSET must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("ser_audio_tx: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   frame_mode_e       mode;
   logic              launch, frame_lvl, frame_flip, frame_fall, word_rise, start;
   logic [WORD_W-1:0] next_word;

   assign mode  = frame_mode_e'(frame_mode_i);
   assign start = (mode == FRM_WORD_CLK) ? word_rise : frame_flip;

   sat_clk_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_clk_i    (bit_clk_i),
      .frame_clk_i  (frame_clk_i),
      .word_clk_i   (word_clk_i),
      .edge_pol_i   (edge_pol_i),
      .launch_o     (launch),
      .frame_lvl_o  (frame_lvl),
      .frame_flip_o (frame_flip),
      .frame_fall_o (frame_fall),
      .word_rise_o  (word_rise)
   );

   sat_sample_bank #(.WORD_W(WORD_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .left_i    (left_i),
      .right_i   (right_i),
      .capture_i (frame_fall),
      .chan_i    (frame_lvl),
      .word_o    (next_word)
   );

   sat_slot_engine #(.WORD_W(WORD_W), .RJ_OFFSET(RJ_OFFSET)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .start_i  (start),
      .mode_i   (mode),
      .mute_i   (mute_i),
      .word_i   (next_word),
      .dout_o   (sdata_o)
   );

   assert_start_on_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> launch);

   assert_word_mode_ignores_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == FRM_WORD_CLK && start) |-> word_rise);

endmodule

// File: tb/ser_audio_tx_tb_top.sv
`timescale 1ns/1ps
module ser_audio_tx_tb_top;

   localparam int W    = 24;
   localparam int RJ   = 16;
   localparam int SYNC = 2;
   localparam int HALF = 3;
   localparam int SLOTS = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, lr = 1'b0, wclk = 1'b0, pol = 1'b0, mute = 1'b0, load = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [W-1:0] left = '0, right = '0;
   logic sdata;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   string cur_tag = "R10 reset";
   bit count_ones = 0;
   int ones = 0;

   always #4 clk = ~clk;

   ser_audio_tx #(.WORD_W(W), .RJ_OFFSET(RJ), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_clk_i(bclk), .frame_clk_i(lr), .word_clk_i(wclk),
      .edge_pol_i(pol), .frame_mode_i(mode), .mute_i(mute), .load_i(load),
      .left_i(left), .right_i(right), .sdata_o(sdata)
   );

   // behavioural reference model
   logic [2:0] hq[$];
   int mcnt = 63;
   logic [W-1:0] mword = '0, mfl = '0, mfr = '0, mlreg = '0, mrreg = '0;
   logic mmute = 0, mbprev = 0, mlprev = 0, mwprev = 0, exp_dout = 0;

   always @(posedge clk) begin
      logic [2:0] syn;
      logic launch, flip, fall, wr, start;
      logic [W-1:0] nfl, nfr;
      int off, rel;
      if (!rst_n) begin
         hq.delete();
         mcnt = 63; mword = '0; mfl = '0; mfr = '0; mlreg = '0; mrreg = '0;
         mmute = 0; mbprev = 0; mlprev = 0; mwprev = 0; exp_dout = 0;
      end else begin
         hq.push_back({wclk, lr, bclk});
         if (hq.size() > SYNC) syn = hq.pop_front(); else syn = 3'b000;
         launch = pol ? (!mbprev && syn[0]) : (mbprev && !syn[0]);
         mbprev = syn[0];
         if (launch) begin
            flip = (syn[1] != mlprev);
            fall = flip && !syn[1];
            wr   = syn[2] && !mwprev;
            mlprev = syn[1];
            mwprev = syn[2];
            start = (mode == 2'b11) ? wr : flip;
            nfl = fall ? mlreg : mfl;
            nfr = fall ? mrreg : mfr;
            if (start) begin
               mcnt = 0; mword = syn[1] ? nfr : nfl; mmute = mute;
            end else if (mcnt < 63) mcnt++;
            mfl = nfl; mfr = nfr;
            off = (mode == 2'b01) ? 1 : (mode == 2'b10) ? RJ : 0;
            rel = mcnt - off;
            exp_dout = (!mmute && rel >= 0 && rel < W) ? mword[W-1-rel] : 1'b0;
         end
         if (load) begin mlreg = left; mrreg = right; end
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (sdata !== exp_dout) begin
            errors++;
            $display("FAIL %s: sdata_o=%0b expected %0b at %0t", cur_tag, sdata, exp_dout, $time);
         end
         if (count_ones && sdata) ones++;
      end
   end

   task automatic run_chan(input logic lvl, input int wpos, input int mute_slot,
                           input logic mute_val, input int load_slot,
                           input logic [W-1:0] nl, input logic [W-1:0] nr,
                           input int gate_slot);
      for (int s = 0; s < SLOTS; s++) begin
         bclk = pol ? 1'b1 : 1'b0;
         if (s == 0) lr = lvl;
         if (s == wpos) wclk = 1'b1;
         if (s == wpos + 3) wclk = 1'b0;
         if (s == mute_slot) mute = mute_val;
         if (s == load_slot) begin left = nl; right = nr; load = 1'b1; end
         @(negedge clk);
         load = 1'b0;
         repeat (HALF - 1) @(negedge clk);
         bclk = ~bclk;
         repeat (HALF) @(negedge clk);
         if (s == gate_slot) repeat (20) @(negedge clk);
      end
   endtask

   task automatic plain_frame(input int wpos);
      run_chan(1'b0, wpos, -1, 1'b0, -1, '0, '0, -1);
      run_chan(1'b1, wpos, -1, 1'b0, -1, '0, '0, -1);
   endtask

   task automatic load_pair(input logic [W-1:0] l, input logic [W-1:0] r);
      left = l; right = r; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic expect_val(input string tag, input int act, input int exp_v, input bit at_least);
      checks++;
      if (at_least ? (act < exp_v) : (act != exp_v)) begin
         errors++;
         $display("FAIL %s: got %0d expected %s%0d", tag, act, at_least ? ">=" : "", exp_v);
      end
   endtask

   initial begin
      repeat (6) @(negedge clk);
      expect_val("R10 output low in reset", int'(sdata), 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cur_tag = "R7 idle before first word";
      run_chan(1'b1, -9, -1, 1'b0, -1, '0, '0, -1);
      load_pair(24'h800001, 24'h7FFFFE);
      cur_tag = "R1 R3 left-aligned mode";
      plain_frame(-9);
      load_pair(24'hC3A50F, 24'h13579B);
      plain_frame(-9);
      cur_tag = "R2 rising launch edge";
      pol = 1'b1;
      plain_frame(-9);
      plain_frame(-9);
      cur_tag = "R4 one-bit delay mode";
      mode = 2'b01;
      plain_frame(-9);
      plain_frame(-9);
      cur_tag = "R5 right-aligned offset mode";
      mode = 2'b10;
      pol = 1'b0;
      plain_frame(-9);
      plain_frame(-9);
      cur_tag = "R6 word clock mode";
      mode = 2'b11;
      plain_frame(4);
      plain_frame(9);
      cur_tag = "R8 mute sampled at word start";
      mode = 2'b00;
      load_pair(24'hA5A5A5, 24'hFFFFFF);
      plain_frame(-9);
      ones = 0; count_ones = 1;
      run_chan(1'b0, -9, 10, 1'b1, -1, '0, '0, -1);
      count_ones = 0;
      expect_val("R8 mid-word mute leaves word intact", ones, 1, 1);
      ones = 0; count_ones = 1;
      run_chan(1'b1, -9, 30, 1'b0, -1, '0, '0, -1);
      count_ones = 0;
      expect_val("R8 muted word all zero", ones, 0, 0);
      plain_frame(-9);
      cur_tag = "R9 mid-frame load";
      run_chan(1'b0, -9, -1, 1'b0, 20, 24'h00FF00, 24'h0F0F0F, -1);
      run_chan(1'b1, -9, -1, 1'b0, -1, '0, '0, -1);
      plain_frame(-9);
      cur_tag = "R11 gated bit clock";
      run_chan(1'b0, -9, -1, 1'b0, -1, '0, '0, 7);
      run_chan(1'b1, -9, -1, 1'b0, -1, '0, '0, 12);
      mode = 2'b10;
      run_chan(1'b0, -9, -1, 1'b0, -1, '0, '0, 20);
      run_chan(1'b1, -9, -1, 1'b0, -1, '0, '0, 30);
      cur_tag = "R10 reset mid-stream";
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      expect_val("R10 output low after reset", int'(sdata), 0, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule